// File: doc/BRIEF.md
# USB OUT Endpoint Receive Bank Controller

This block sits between the packet layer of a USB device and a CPU. It stores the OUT data packets of one endpoint in one or two fixed-size byte banks. A packet arrives as a byte stream framed by a start strobe and an end strobe. At the end strobe the block also receives a flag that says whether the packet passed its CRC check. Once a packet has been committed to a bank, the CPU sees a bank-ready indication and the number of stored bytes. It reads the bytes in order through a read strobe and then hands the bank back with a release strobe.

Four sticky event flags report packet completion, CRC failure, truncation of an oversized packet and loss of a packet that found no free bank. Each flag has an enable bit, and the interrupt output is raised when any enabled flag is set. With two banks, the packet side fills the banks in alternating order and the CPU side drains them in the same order, so one packet can be read while the next one arrives.

Top module: `out_ep_rxbanks`

## Requirements
- R1: A packet that fits in a bank is stored in full. While that bank is at the read side, `cpu_count` equals its length and `cpu_rdata` presents the bytes in arrival order, one step per accepted read.
- R2: A packet longer than BANK_BYTES keeps only its first BANK_BYTES bytes and drops the rest. Its count reads BANK_BYTES, and it sets both the overflow flag (bit 2) and the received flag (bit 0).
- R3: A packet whose start strobe finds the bank it would fill still occupied is discarded and sets the underflow flag (bit 3). Banks that were already stored are left unchanged.
- R4: A packet that ends with `pkt_crc_ok` low sets the stall-type error flag (bit 1) and also sets the received flag (bit 0).
- R5: A read strobe advances the read position only when the received flag or `rwal` is high and unread bytes remain. Any other read strobe has no effect on the data later presented.
- R6: `rwal` is high exactly when the bank at the read side holds a packet. A release strobe while `rwal` is high frees that bank and moves the read side on. A release strobe while `rwal` is low is ignored.
- R7: With DUAL_BANK=1, packets fill bank 0 and bank 1 alternately and are read back in the same order. Up to two packets can be held before one is lost.
- R8: The flags use these bit positions: bit 0 received, bit 1 CRC error, bit 2 overflow, bit 3 underflow. Each flag stays set until a 1 is written to its bit of `flag_clr`. If a flag is set and cleared in the same cycle, it stays set.
- R9: `irq` is high when any flag is set whose bit in `flag_en` is also set.
- R10: A synchronous active-high `rst` empties every bank and clears all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_start | input | 1 | Start of an OUT data packet |
| pkt_valid | input | 1 | `pkt_data` holds a payload byte |
| pkt_data | input | 8 | Payload byte |
| pkt_end | input | 1 | End of packet, with no byte in the same cycle |
| pkt_crc_ok | input | 1 | CRC result, sampled together with `pkt_end` |
| cpu_rd | input | 1 | Read strobe, advances to the next byte |
| cpu_rdata | output | 8 | Byte at the current read position |
| cpu_count | output | $clog2(BANK_BYTES+1) | Byte count of the read-side bank (0 when empty) |
| cpu_release | input | 1 | Frees the read-side bank |
| rwal | output | 1 | Read-side bank holds a packet |
| flag_en | input | 4 | Interrupt enable for each flag |
| flag_clr | input | 4 | Write-one-to-clear for each flag |
| flags | output | 4 | Sticky event flags |
| irq | output | 1 | OR of the enabled flags |

## Verification
All state is registered, so every result appears one clock after the edge that samples its cause. The underflow flag follows the start strobe by one cycle. Received, error and overflow flags, `rwal` and `cpu_count` follow the end strobe by one cycle. The next byte follows an accepted read by one cycle, and `irq` changes in the same cycle as the flag that drives it. The bench drives inputs on the falling edge and compares against its own bank model on the next falling edge, which is half a cycle after the register update. It checks `cpu_rdata` before raising each read strobe.

// File: rtl/out_ep_pkg.sv
package out_ep_pkg;
    localparam int NFLAGS    = 4;
    localparam int FLG_RX    = 0;
    localparam int FLG_STALL = 1;
    localparam int FLG_OVF   = 2;
    localparam int FLG_UNF   = 3;
endpackage

// File: rtl/out_ep_bank_mem.sv
module out_ep_bank_mem #(
    parameter int NBANK = 2,
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic          wbank,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic          rbank,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] lane_q [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [7:0] store_q [DEPTH];
        always_ff @(posedge clk) begin
            if (we && (int'(wbank) == b)) store_q[waddr] <= wdata;
        end
        assign lane_q[b] = store_q[raddr];
    end

    if (NBANK > 1) begin : g_mux2
        assign rdata = lane_q[rbank];
    end else begin : g_mux1
        logic unused_rbank;
        assign unused_rbank = rbank;
        assign rdata = lane_q[0];
    end
endmodule

// File: rtl/out_ep_irq_flags.sv
module out_ep_irq_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] en,
    output logic [N-1:0] flags,
    output logic         irq
);
    logic [N-1:0] flag_d, flag_q;

    always_comb begin
        flag_d = (flag_q & ~clr) | set;
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= flag_d;
    end

    assign flags = flag_q;
    assign irq   = |(flag_q & en);
endmodule

// File: rtl/out_ep_rxbanks.sv
module out_ep_rxbanks
    import out_ep_pkg::*;
#(
    parameter int BANK_BYTES = 64,
    parameter bit DUAL_BANK  = 1'b1,
    parameter int CW         = $clog2(BANK_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pkt_start,
    input  logic              pkt_valid,
    input  logic [7:0]        pkt_data,
    input  logic              pkt_end,
    input  logic              pkt_crc_ok,
    input  logic              cpu_rd,
    output logic [7:0]        cpu_rdata,
    output logic [CW-1:0]     cpu_count,
    input  logic              cpu_release,
    output logic              rwal,
    input  logic [NFLAGS-1:0] flag_en,
    input  logic [NFLAGS-1:0] flag_clr,
    output logic [NFLAGS-1:0] flags,
    output logic              irq
);
    localparam int NBANK = DUAL_BANK ? 2 : 1;
    localparam int AW    = $clog2(BANK_BYTES);

    typedef struct packed {
        logic [NBANK-1:0]         full;
        logic [NBANK-1:0][CW-1:0] cnt;
        logic                     wr_bank;
        logic                     rd_bank;
        logic                     cap;
        logic                     ovf;
        logic [CW-1:0]            wcnt;
        logic [CW-1:0]            rd_ptr;
    } st_t;

    st_t               st_d, st_q;
    logic              mem_we;
    logic [NFLAGS-1:0] flag_set;
    logic              read_ok;

    always_comb begin
        st_d     = st_q;
        mem_we   = 1'b0;
        flag_set = '0;
        read_ok  = cpu_rd && (flags[FLG_RX] || st_q.full[st_q.rd_bank])
                   && (st_q.rd_ptr < st_q.cnt[st_q.rd_bank]);

        // CPU side
        if (read_ok) st_d.rd_ptr = st_q.rd_ptr + 1'b1;
        if (cpu_release && st_q.full[st_q.rd_bank]) begin
            st_d.full[st_q.rd_bank] = 1'b0;
            st_d.cnt[st_q.rd_bank]  = '0;
            st_d.rd_ptr             = '0;
            if (NBANK > 1) st_d.rd_bank = ~st_q.rd_bank;
        end

        // packet side
        if (pkt_start) begin
            st_d.wcnt = '0;
            st_d.ovf  = 1'b0;
            if (st_q.full[st_q.wr_bank]) begin
                st_d.cap           = 1'b0;
                flag_set[FLG_UNF]  = 1'b1;
            end else begin
                st_d.cap = 1'b1;
            end
        end else if (st_q.cap && pkt_valid) begin
            if (st_q.wcnt < CW'(BANK_BYTES)) begin
                mem_we    = 1'b1;
                st_d.wcnt = st_q.wcnt + 1'b1;
            end else begin
                st_d.ovf = 1'b1;
            end
        end else if (st_q.cap && pkt_end) begin
            st_d.cap                  = 1'b0;
            st_d.full[st_q.wr_bank]   = 1'b1;
            st_d.cnt[st_q.wr_bank]    = st_q.wcnt;
            flag_set[FLG_RX]          = 1'b1;
            flag_set[FLG_OVF]         = st_q.ovf;
            flag_set[FLG_STALL]       = !pkt_crc_ok;
            if (NBANK > 1) st_d.wr_bank = ~st_q.wr_bank;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    out_ep_bank_mem #(.NBANK(NBANK), .DEPTH(BANK_BYTES), .AW(AW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .wbank (st_q.wr_bank),
        .waddr (st_q.wcnt[AW-1:0]),
        .wdata (pkt_data),
        .rbank (st_q.rd_bank),
        .raddr (st_q.rd_ptr[AW-1:0]),
        .rdata (cpu_rdata)
    );

    out_ep_irq_flags #(.N(NFLAGS)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .set   (flag_set),
        .clr   (flag_clr),
        .en    (flag_en),
        .flags (flags),
        .irq   (irq)
    );

    assign rwal      = st_q.full[st_q.rd_bank];
    assign cpu_count = st_q.cnt[st_q.rd_bank];
endmodule

// File: rtl/out_ep_rxbanks_chk.sv
module out_ep_rxbanks_chk #(
    parameter int BANK_BYTES = 64,
    parameter int CW         = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          pkt_end,
    input logic          cpu_rd,
    input logic          cpu_release,
    input logic          rwal,
    input logic [3:0]    flags,
    input logic [3:0]    flag_clr,
    input logic [CW-1:0] cpu_count,
    input logic [CW-1:0] rd_ptr
);
    // R1
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_count <= CW'(BANK_BYTES));

    // R2
    ovf_with_rx_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[2]) |-> flags[0]);

    // R4
    stall_with_rx_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[1]) |-> flags[0]);

    // R5
    ignored_read_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && !rwal && !flags[0] && !cpu_release) |=> $stable(rd_ptr));

    // R6
    rwal_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rwal) |-> $past(pkt_end));

    // R8
    rx_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flags[0] && !flag_clr[0]) |=> flags[0]);

    // R10
    reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rwal && flags == 4'b0000 && cpu_count == '0));
endmodule

bind out_ep_rxbanks out_ep_rxbanks_chk #(.BANK_BYTES(BANK_BYTES), .CW(CW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pkt_end     (pkt_end),
    .cpu_rd      (cpu_rd),
    .cpu_release (cpu_release),
    .rwal        (rwal),
    .flags       (flags),
    .flag_clr    (flag_clr),
    .cpu_count   (cpu_count),
    .rd_ptr      (st_q.rd_ptr)
);

// File: tb/out_ep_rxbanks_bench.sv
`timescale 1ns/1ps
module out_ep_rxbanks_bench;
    localparam int B  = 64;
    localparam int CW = $clog2(B + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pkt_start = 0, pkt_valid = 0, pkt_end = 0, pkt_crc_ok = 0;
    logic [7:0]    pkt_data = 0;
    logic          cpu_rd = 0, cpu_release = 0;
    logic [7:0]    cpu_rdata;
    logic [CW-1:0] cpu_count;
    logic          rwal, irq;
    logic [3:0]    flag_en = 0, flag_clr = 0, flags;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    // bank model
    byte unsigned bdata [2][B];
    int           blen  [2];
    bit           bfull [2];
    int           mwr = 0, mrd = 0;
    logic [3:0]   mfl = 0;

    always #2.5 clk = ~clk;

    out_ep_rxbanks u_out_ep_rxbanks (
        .clk(clk), .rst(rst), .pkt_start(pkt_start), .pkt_valid(pkt_valid),
        .pkt_data(pkt_data), .pkt_end(pkt_end), .pkt_crc_ok(pkt_crc_ok),
        .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .cpu_count(cpu_count),
        .cpu_release(cpu_release), .rwal(rwal), .flag_en(flag_en),
        .flag_clr(flag_clr), .flags(flags), .irq(irq)
    );

    function automatic int exp_count();
        return bfull[mrd] ? blen[mrd] : 0;
    endfunction

    function automatic bit exp_irq(logic [3:0] f, logic [3:0] e);
        return |(f & e);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_state(string req);
        chk({req, " flags"}, int'(flags), int'(mfl));
        chk({req, " rwal R6"}, int'(rwal), int'(bfull[mrd]));
        chk({req, " count"}, int'(cpu_count), exp_count());
        chk("R9 irq", int'(irq), int'(exp_irq(mfl, flag_en)));
    endtask

    task automatic send_pkt(int len, bit crc, logic [3:0] clr_end, string req);
        bit drop;
        @(negedge clk) pkt_start = 1;
        @(negedge clk) pkt_start = 0;
        drop = bfull[mwr];
        if (drop) mfl[3] = 1'b1;
        for (int i = 0; i < len; i++) begin
            pkt_valid = 1;
            pkt_data  = 8'($urandom);
            if (!drop && i < B) bdata[mwr][i] = pkt_data;
            @(negedge clk);
        end
        pkt_valid  = 0;
        pkt_end    = 1;
        pkt_crc_ok = crc;
        flag_clr   = clr_end;
        @(negedge clk);
        pkt_end  = 0;
        flag_clr = 0;
        mfl = mfl & ~clr_end;
        if (!drop) begin
            blen[mwr]  = (len > B) ? B : len;
            bfull[mwr] = 1;
            mfl[0] = 1'b1;
            if (len > B) mfl[2] = 1'b1;
            if (!crc)    mfl[1] = 1'b1;
            mwr ^= 1;
        end
        check_state(req);
    endtask

    task automatic drain(string req);
        if (!bfull[mrd]) begin
            cpu_release = 1;
            @(negedge clk) cpu_release = 0;
            check_state({req, " R6 idle release"});
            return;
        end
        chk({req, " R1 count"}, int'(cpu_count), blen[mrd]);
        for (int i = 0; i < blen[mrd]; i++) begin
            chk({req, " R1 data"}, int'(cpu_rdata), int'(bdata[mrd][i]));
            cpu_rd = 1;
            @(negedge clk);
        end
        cpu_rd = 0;
        cpu_release = 1;
        @(negedge clk) cpu_release = 0;
        bfull[mrd] = 0;
        mrd ^= 1;
        check_state({req, " R6 after release"});
    endtask

    task automatic clear_flags(logic [3:0] m);
        flag_clr = m;
        @(negedge clk) flag_clr = 0;
        mfl = mfl & ~m;
        check_state("R8 clear");
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed);
        blen[0] = 0; blen[1] = 0; bfull[0] = 0; bfull[1] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10 reset state
        check_state("R10 reset");
        flag_en = 4'hF;

        // R5: reads while empty and no flag are ignored
        cpu_rd = 1;
        repeat (3) @(negedge clk);
        cpu_rd = 0;
        send_pkt(5, 1, 4'h0, "R1 short");
        drain("R5 first byte after ignored reads");
        clear_flags(4'hF);

        // R2 oversize
        send_pkt(B + 6, 1, 4'h0, "R2 oversize");
        chk("R2 truncated count", int'(cpu_count), B);
        chk("R2 overflow flag", int'(flags[2]), 1);
        drain("R2");
        clear_flags(4'hF);

        // R4 crc bad
        send_pkt(3, 0, 4'h0, "R4 crc bad");
        chk("R4 rx flag too", int'(flags[0]), 1);
        drain("R4");
        clear_flags(4'hF);

        // R3/R7: two banks full, third packet lost
        send_pkt(4, 1, 4'h0, "R7 bank0");
        send_pkt(6, 1, 4'h0, "R7 bank1");
        send_pkt(8, 1, 4'h0, "R3 lost");
        chk("R3 underflow flag", int'(flags[3]), 1);
        drain("R7 first order");
        drain("R7 second order");
        clear_flags(4'hF);

        // R8 set wins over clear in the same cycle
        send_pkt(2, 1, 4'h1, "R8 set wins");
        chk("R8 rx kept", int'(flags[0]), 1);
        clear_flags(4'h1);
        drain("R8");

        // R9 with partial enables
        flag_en = 4'b0100;
        send_pkt(1, 0, 4'h0, "R9 masked");
        chk("R9 masked irq", int'(irq), 0);
        drain("R9");
        clear_flags(4'hF);

        // random mix
        for (int it = 0; it < 80; it++) begin
            flag_en = 4'($urandom);
            case ($urandom_range(0, 3))
                0, 1: send_pkt($urandom_range(0, B + 4), 1'($urandom), 4'($urandom), "R1 random pkt");
                2:    drain("R6 random drain");
                default: clear_flags(4'($urandom));
            endcase
        end
        drain("R7 final a");
        drain("R7 final b");

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule